// File: doc/BRIEF.md
# USB PHY Power-Up Reset Sequencer

This block brings a dual-speed USB host controller and its PHY out of reset without software pacing each step. A one-cycle start pulse launches a fixed program. It asserts the PHY, host-controller and glue-logic resets. It cycles the controller clock divider through its reset. It programs the reference-clock configuration and powers the PHY up. It then releases the three resets in a fixed order, with a settle interval counted in controller-clock cycles between releases, and raises a done flag.

The reference-clock fields are derived in hardware from two inputs. One is a 2-bit reference source select. The other is a 2-bit reference frequency code. Both are captured at the step that powers the PHY. Running the block again only takes another start pulse once done is high. A pulse that arrives while a sequence is in flight has no effect.

Top module: `usb_pwrup_seq`

## Requirements
- R1: After reset, phy_rst_o, hc_rst_o and glue_rst_o are 1 and mode_o is 1. done_o, div_rst_o, every enable and every configuration field are 0.
- R2: A start pulse accepted while idle or done sets all three resets to 1 together, clears done_o, and returns every other output to its reset value at the next clock edge (step 0).
- R3: At step 1 div_rst_o is 1. At step 2 div_en_o is 1 and div_sel_o equals DIV_SEL. At step 3 div_rst_o returns to 0 while div_en_o stays 1.
- R4: mult_o is 0x32 for frequency code 1 (50 MHz) and 0x28 for code 2 (125 MHz). It is 0x19 for code 0 (100 MHz) and for the unsupported code 3.
- R5: fsel_o is 0x27 when source select is 0 or 1 and the frequency code is 0 or 3. It is 0x07 otherwise. ref_sel_o equals the source select, and div2_o is always 0.
- R6: At step 4, ssc_en_o, ref_ss_en_o, hs_pwr_o, ss_pwr_o and the reference fields (ref_sel_o, mult_o, fsel_o) all take their values in the same cycle.
- R7: glue_rst_o falls exactly WAIT_CYC cycles after the power-up step (step 4+WAIT_CYC).
- R8: WAIT_CYC cycles after the glue release, ppc_en_o rises and hc_rst_o falls in the same cycle.
- R9: WAIT_CYC cycles after the host-controller release, if_clk_en_o becomes 1 and mode_o becomes 0. One cycle later phy_rst_o falls and done_o rises; phy_rst_o is the last reset released.
- R10: A start pulse during a running sequence is ignored: every output follows the same timeline as without it.
- R11: done_o stays 1 while start_i is low, and a start pulse while done restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| ref_src_i | input | 2 | Reference source select |
| freq_code_i | input | 2 | Reference frequency code: 0=100, 1=50, 2=125 MHz, 3 unsupported |
| phy_rst_o | output | 1 | PHY reset |
| hc_rst_o | output | 1 | Host-controller reset |
| glue_rst_o | output | 1 | Glue-logic reset |
| div_rst_o | output | 1 | Controller clock divider reset |
| div_en_o | output | 1 | Controller clock enable |
| div_sel_o | output | 3 | Controller clock divider select |
| ref_sel_o | output | 2 | Reference source field |
| mult_o | output | 7 | PLL multiplier |
| fsel_o | output | 6 | Reference frequency select |
| div2_o | output | 1 | Reference divide-by-2, held at 0 |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| ref_ss_en_o | output | 1 | SuperSpeed reference enable |
| hs_pwr_o | output | 1 | High-speed PHY power enable |
| ss_pwr_o | output | 1 | SuperSpeed PHY power enable |
| ppc_en_o | output | 1 | Port power control enable |
| if_clk_en_o | output | 1 | Interface clock enable |
| mode_o | output | 1 | Controller mode, 0 = host |
| done_o | output | 1 | Sequence complete |

## Verification
The bench builds the block with WAIT_CYC at its default of 10 and DIV_SEL set to 5, so the divider value differs from the reset value. It sweeps all sixteen combinations of source select and frequency code. It compares every output at every step of each run against a timeline computed from the step index. Runs follow one another without a reset, so each one also exercises the restart path from done. Stray start pulses are injected at early, middle and late steps of chosen runs to show they are ignored.

// File: rtl/usb_pwrup_pkg.sv
package usb_pwrup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DIV_RST, ST_DIV_CFG, ST_DIV_REL, ST_PWR_UP,
    ST_WAIT_GLUE, ST_WAIT_HC, ST_WAIT_IF, ST_PHY_REL, ST_DONE
  } seq_state_t;

  localparam int MULT_W = 7;
  localparam int FSEL_W = 6;

  // PLL multiplier from the frequency code; code 3 falls back to 100 MHz
  function automatic logic [MULT_W-1:0] pll_mult(input logic [1:0] fcode);
    case (fcode)
      2'd1:    pll_mult = 7'h32;
      2'd2:    pll_mult = 7'h28;
      default: pll_mult = 7'h19;
    endcase
  endfunction

  // frequency select: the shared-source 100 MHz case is the only special one
  function automatic logic [FSEL_W-1:0] ref_fsel(input logic [1:0] src,
                                                 input logic [1:0] fcode);
    logic at_100;
    at_100   = (fcode == 2'd0) || (fcode == 2'd3);
    ref_fsel = (!src[1] && at_100) ? 6'h27 : 6'h07;
  endfunction

endpackage

// File: rtl/seq_wait_ctr.sv
module seq_wait_ctr #(
  parameter int WAIT_CYC = 10,
  localparam int CNT_W = $clog2(WAIT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(WAIT_CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_refcfg.sv
module seq_refcfg
  import usb_pwrup_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              cap_i,
  input  logic [1:0]        src_i,
  input  logic [1:0]        fcode_i,
  output logic [1:0]        ref_sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [FSEL_W-1:0] fsel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sel_o <= '0;
      mult_o    <= '0;
      fsel_o    <= '0;
    end else if (clr_i) begin
      ref_sel_o <= '0;
      mult_o    <= '0;
      fsel_o    <= '0;
    end else if (cap_i) begin
      ref_sel_o <= src_i;
      mult_o    <= pll_mult(fcode_i);
      fsel_o    <= ref_fsel(src_i, fcode_i);
    end
  end
endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq
  import usb_pwrup_pkg::*;
#(
  parameter int WAIT_CYC = 10,
  parameter int DSEL_W   = 3,
  parameter logic [DSEL_W-1:0] DIV_SEL = 3'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        ref_src_i,
  input  logic [1:0]        freq_code_i,
  output logic              phy_rst_o,
  output logic              hc_rst_o,
  output logic              glue_rst_o,
  output logic              div_rst_o,
  output logic              div_en_o,
  output logic [DSEL_W-1:0] div_sel_o,
  output logic [1:0]        ref_sel_o,
  output logic [MULT_W-1:0] mult_o,
  output logic [FSEL_W-1:0] fsel_o,
  output logic              div2_o,
  output logic              ssc_en_o,
  output logic              ref_ss_en_o,
  output logic              hs_pwr_o,
  output logic              ss_pwr_o,
  output logic              ppc_en_o,
  output logic              if_clk_en_o,
  output logic              mode_o,
  output logic              done_o
);
  seq_state_t state_q;

  // named internal events, also used by the checker
  logic seq_busy, start_accept, wait_done, in_wait, ctr_load, pwr_step;

  assign seq_busy     = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign start_accept = start_i && !seq_busy;
  assign in_wait      = (state_q == ST_WAIT_GLUE) || (state_q == ST_WAIT_HC) ||
                        (state_q == ST_WAIT_IF);
  assign pwr_step     = (state_q == ST_PWR_UP);
  assign ctr_load     = pwr_step || (in_wait && wait_done);
  assign div2_o       = 1'b0;

  seq_wait_ctr #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst_n(rst_n), .load_i(ctr_load), .zero_o(wait_done)
  );

  seq_refcfg u_ref (
    .clk(clk), .rst_n(rst_n), .clr_i(start_accept), .cap_i(pwr_step),
    .src_i(ref_src_i), .fcode_i(freq_code_i),
    .ref_sel_o(ref_sel_o), .mult_o(mult_o), .fsel_o(fsel_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phy_rst_o   <= 1'b1;
      hc_rst_o    <= 1'b1;
      glue_rst_o  <= 1'b1;
      div_rst_o   <= 1'b0;
      div_en_o    <= 1'b0;
      div_sel_o   <= '0;
      ssc_en_o    <= 1'b0;
      ref_ss_en_o <= 1'b0;
      hs_pwr_o    <= 1'b0;
      ss_pwr_o    <= 1'b0;
      ppc_en_o    <= 1'b0;
      if_clk_en_o <= 1'b0;
      mode_o      <= 1'b1;
      done_o      <= 1'b0;
    end else if (start_accept) begin
      state_q     <= ST_DIV_RST;
      phy_rst_o   <= 1'b1;
      hc_rst_o    <= 1'b1;
      glue_rst_o  <= 1'b1;
      div_rst_o   <= 1'b0;
      div_en_o    <= 1'b0;
      div_sel_o   <= '0;
      ssc_en_o    <= 1'b0;
      ref_ss_en_o <= 1'b0;
      hs_pwr_o    <= 1'b0;
      ss_pwr_o    <= 1'b0;
      ppc_en_o    <= 1'b0;
      if_clk_en_o <= 1'b0;
      mode_o      <= 1'b1;
      done_o      <= 1'b0;
    end else begin
      case (state_q)
        ST_DIV_RST: begin
          div_rst_o <= 1'b1;
          state_q   <= ST_DIV_CFG;
        end
        ST_DIV_CFG: begin
          div_sel_o <= DIV_SEL;
          div_en_o  <= 1'b1;
          state_q   <= ST_DIV_REL;
        end
        ST_DIV_REL: begin
          div_rst_o <= 1'b0;
          state_q   <= ST_PWR_UP;
        end
        ST_PWR_UP: begin
          ssc_en_o    <= 1'b1;
          ref_ss_en_o <= 1'b1;
          hs_pwr_o    <= 1'b1;
          ss_pwr_o    <= 1'b1;
          state_q     <= ST_WAIT_GLUE;
        end
        ST_WAIT_GLUE: if (wait_done) begin
          glue_rst_o <= 1'b0;
          state_q    <= ST_WAIT_HC;
        end
        ST_WAIT_HC: if (wait_done) begin
          ppc_en_o <= 1'b1;
          hc_rst_o <= 1'b0;
          state_q  <= ST_WAIT_IF;
        end
        ST_WAIT_IF: if (wait_done) begin
          if_clk_en_o <= 1'b1;
          mode_o      <= 1'b0;
          state_q     <= ST_PHY_REL;
        end
        ST_PHY_REL: begin
          phy_rst_o <= 1'b0;
          done_o    <= 1'b1;
          state_q   <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usb_pwrup_seq_chk.sv
module usb_pwrup_seq_chk #(
  parameter int WAIT_CYC = 10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       start_accept,
  input logic       seq_busy,
  input logic       phy_rst_o,
  input logic       hc_rst_o,
  input logic       glue_rst_o,
  input logic       div_rst_o,
  input logic       div_en_o,
  input logic       ssc_en_o,
  input logic       ref_ss_en_o,
  input logic       hs_pwr_o,
  input logic       ss_pwr_o,
  input logic       ppc_en_o,
  input logic       if_clk_en_o,
  input logic [6:0] mult_o,
  input logic       done_o
);
  logic [15:0] gap_q;

  // cycles since PHY power came up, checked at the glue release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 gap_q <= '0;
    else if ($rose(hs_pwr_o))                   gap_q <= 16'd1;
    else if (gap_q != '0 && gap_q != 16'hFFFF)  gap_q <= gap_q + 16'd1;
  end

  a_r2_resets_together: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> (phy_rst_o && hc_rst_o && glue_rst_o && !done_o));

  a_r6_power_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_pwr_o) |-> (ss_pwr_o && ssc_en_o && ref_ss_en_o && div_en_o && !div_rst_o));

  a_r4_mult_legal: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pwr_o |-> (mult_o == 7'h19 || mult_o == 7'h32 || mult_o == 7'h28));

  a_r7_glue_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glue_rst_o) |-> (gap_q == 16'(WAIT_CYC)));

  a_r8_hc_after_glue: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hc_rst_o) |-> (!glue_rst_o && ppc_en_o));

  a_r9_phy_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_rst_o) |-> (!hc_rst_o && !glue_rst_o && if_clk_en_o && done_o));

  a_r10_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && start_i && !glue_rst_o) |=> !glue_rst_o);

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
endmodule

bind usb_pwrup_seq usb_pwrup_seq_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_accept(start_accept),
  .seq_busy(seq_busy), .phy_rst_o(phy_rst_o), .hc_rst_o(hc_rst_o),
  .glue_rst_o(glue_rst_o), .div_rst_o(div_rst_o), .div_en_o(div_en_o),
  .ssc_en_o(ssc_en_o), .ref_ss_en_o(ref_ss_en_o), .hs_pwr_o(hs_pwr_o),
  .ss_pwr_o(ss_pwr_o), .ppc_en_o(ppc_en_o), .if_clk_en_o(if_clk_en_o),
  .mult_o(mult_o), .done_o(done_o)
);

// File: tb/usb_pwrup_seq_bench.sv
module usb_pwrup_seq_bench;
  localparam int CLK_P  = 10;
  localparam int WAIT   = 10;
  localparam int DSEL   = 5;
  localparam int T_PWR  = 4;
  localparam int T_GLUE = T_PWR + WAIT;
  localparam int T_HC   = T_GLUE + WAIT;
  localparam int T_IF   = T_HC + WAIT;
  localparam int T_PHY  = T_IF + 1;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic [1:0] ref_src_i = '0, freq_code_i = '0;
  logic phy_rst_o, hc_rst_o, glue_rst_o, div_rst_o, div_en_o, div2_o;
  logic [2:0] div_sel_o;
  logic [1:0] ref_sel_o;
  logic [6:0] mult_o;
  logic [5:0] fsel_o;
  logic ssc_en_o, ref_ss_en_o, hs_pwr_o, ss_pwr_o, ppc_en_o, if_clk_en_o;
  logic mode_o, done_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  usb_pwrup_seq #(.WAIT_CYC(WAIT), .DIV_SEL(3'(DSEL))) u_usb_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_src_i(ref_src_i),
    .freq_code_i(freq_code_i), .phy_rst_o(phy_rst_o), .hc_rst_o(hc_rst_o),
    .glue_rst_o(glue_rst_o), .div_rst_o(div_rst_o), .div_en_o(div_en_o),
    .div_sel_o(div_sel_o), .ref_sel_o(ref_sel_o), .mult_o(mult_o),
    .fsel_o(fsel_o), .div2_o(div2_o), .ssc_en_o(ssc_en_o),
    .ref_ss_en_o(ref_ss_en_o), .hs_pwr_o(hs_pwr_o), .ss_pwr_o(ss_pwr_o),
    .ppc_en_o(ppc_en_o), .if_clk_en_o(if_clk_en_o), .mode_o(mode_o),
    .done_o(done_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected outputs at step k, computed from the requirements
  task automatic check_step(input int k, input int src, input int fc);
    int mhz, mul, fs;
    bit up;
    mhz = (fc == 1) ? 50 : (fc == 2) ? 125 : 100;
    mul = (mhz == 50) ? 50 : (mhz == 125) ? 40 : 25;
    fs  = (src < 2 && mhz == 100) ? 39 : 7;
    up  = (k >= T_PWR);
    chk("R2", "phy/hc/glue reset", {phy_rst_o, hc_rst_o, glue_rst_o},
        {k < T_PHY, k < T_HC, k < T_GLUE});
    chk("R3", "div_rst", div_rst_o, (k >= 1 && k < 3));
    chk("R3", "div_en", div_en_o, k >= 2);
    chk("R3", "div_sel", div_sel_o, (k >= 2) ? DSEL : 0);
    chk("R4", "mult", mult_o, up ? mul : 0);
    chk("R5", "fsel", fsel_o, up ? fs : 0);
    chk("R5", "ref_sel/div2", {ref_sel_o, div2_o}, up ? src * 2 : 0);
    chk("R6", "ssc/refss/hs/ss", {ssc_en_o, ref_ss_en_o, hs_pwr_o, ss_pwr_o}, up ? 15 : 0);
    chk("R7", "glue release", glue_rst_o, k < T_GLUE);
    chk("R8", "ppc_en", ppc_en_o, k >= T_HC);
    chk("R9", "if_clk/mode", {if_clk_en_o, mode_o}, (k >= T_IF) ? 2 : 1);
    chk("R9", "done", done_o, k >= T_PHY);
  endtask

  // one run; inj >= 0 places a stray start pulse after step inj (R10)
  task automatic run_seq(input int src, input int fc, input int inj);
    @(negedge clk);
    ref_src_i = 2'(src);
    freq_code_i = 2'(fc);
    start_i = 1'b1;
    for (int k = 0; k <= T_PHY; k++) begin
      @(negedge clk);
      start_i = (k == inj);
      check_step(k, src, fc);
    end
    start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R11", "done holds", done_o, 1);
      chk("R11", "phy_rst stays low", phy_rst_o, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "resets", {phy_rst_o, hc_rst_o, glue_rst_o}, 7);
    chk("R1", "mode", mode_o, 1);
    chk("R1", "done/div_rst/div_en", {done_o, div_rst_o, div_en_o}, 0);
    chk("R1", "enables", {ssc_en_o, ref_ss_en_o, hs_pwr_o, ss_pwr_o, ppc_en_o, if_clk_en_o}, 0);
    chk("R1", "fields", {div_sel_o, ref_sel_o, mult_o, fsel_o, div2_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "idle after reset release", {phy_rst_o, done_o}, 2);
    for (int s = 0; s < 4; s++) begin
      for (int f = 0; f < 4; f++) begin
        int inj;
        inj = (s == 2 && f == 1) ? 10 : (s == 1 && f == 3) ? 2 :
              (s == 3 && f == 0) ? T_PHY - 1 : -1;
        run_seq(s, f, inj);
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule